// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block decides, for every access on a 32-bit address, whether it may proceed and which memory type it belongs to. Twelve regions can be programmed. Each has a base address, a power-of-two size, eight subregions that can be switched off one by one, a 3-bit permission code, an execute-never bit and a memory-type encoding. Where regions overlap, the highest-numbered region that hits wins. An address in a disabled subregion falls through to the lower regions, or to a background attribute set when no region hits.

Software programs the block through a small write-only configuration port, and only at the privileged level. It first writes a region select and then that region's base, attribute and size/enable words. Two more words hold the control bits and the background attribute set. The check port takes one access per cycle. One cycle later it returns a fault flag, a fault class and the resolved memory type.

Top module: `mpu_guard`

## Requirements
- R1: After reset every region is disabled, the global enable and the background enable are 0, `rsp_valid` and `cfg_err` are 0, and the background attribute word is 0x303 (full access, normal memory).
- R2: A request with `chk_valid`=1 yields `rsp_valid`=1 one cycle later. With the global enable at 0, every access reports `rsp_fault`=0, class 0 (none) and type 2 (normal).
- R3: A privileged write with `cfg_addr` 0 loads the region select from `cfg_wdata[3:0]`. Values 12 to 15 are ignored and the select keeps its old value. `cfg_addr` 1, 2 and 3 write the base, attribute and size/enable words of the selected region. `cfg_addr` 4 writes the control word (bit 0 global enable, bit 1 background enable). `cfg_addr` 5 writes the background attribute word.
- R4: A configuration write with `cfg_priv`=0 changes nothing, and `cfg_err` is 1 in the following cycle. A privileged write leaves `cfg_err` at 0.
- R5: A region with size code N (size word bits [5:1], enable at bit 0) covers 2^(N+1) bytes, from code 4 (32 B) to code 31 (4 GB). Its base (bits [31:5]) is masked down to the region size. A region with a code below 4, or with enable 0, never matches.
- R6: When several enabled regions match, the attributes of the highest-numbered one apply.
- R7: Bit 8+k of the size word disables subregion k, each subregion being one eighth of the region with subregion 0 lowest. An access in a disabled subregion does not match that region and falls through.
- R8: With the global enable at 1, an access matching no region gives a background fault (class 1, type 0). If the background enable is 1, it takes the background attribute word instead.
- R9: Permission code (attribute bits [10:8]): 000 no access; 001 privileged read/write only; 010 privileged read/write, user read; 011 full access; 101 privileged read only; 110 read only for both. A violation gives class 2 (permission). `chk_kind` 0 is a read, 1 a write, 2 an instruction fetch (checked as a read); `chk_priv`=1 is privileged.
- R10: With execute-never (attribute bit 12) set, a fetch gives a permission fault.
- R11: Type fields: TEX in bits [5:3], C in bit 1, B in bit 0. 000/0/0 is strongly-ordered (type 0), 000/0/1 is device (type 1), and 000/1/x, 001/0/0 and 001/1/1 are normal (type 2).
- R12: An access with `chk_unaligned`=1 to a device or strongly-ordered location gives an alignment fault (class 3). The alignment fault takes precedence over a permission fault.
- R13: Permission code 100 or 111, or an unlisted TEX/C/B combination, gives a permission fault on every access, with type 0 reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_priv | input | 1 | Writer is privileged |
| cfg_err | output | 1 | Previous cycle held a rejected user-level write |
| chk_valid | input | 1 | Access request present |
| chk_addr | input | 32 | Access address |
| chk_priv | input | 1 | Access is privileged |
| chk_kind | input | 2 | 0 read, 1 write, 2 fetch |
| chk_unaligned | input | 1 | Access is not naturally aligned |
| rsp_valid | output | 1 | Result present |
| rsp_fault | output | 1 | Access faulted |
| rsp_class | output | 2 | 0 none, 1 background, 2 permission, 3 alignment |
| rsp_mtype | output | 2 | 0 strongly-ordered, 1 device, 2 normal |

## Verification
The bench builds the block with its default of twelve regions. This makes region 11 the top of the priority order and makes 12 the first reserved select value, so both the winner of a full-space overlap and the rejected select are reachable. The region sizes used run from 64 KB through 256 MB up to the 4 GB code. Together they exercise the size mask at a small, a mid and the all-covering end, and the subregion index at an 8 KB step.

// File: rtl/mpu_guard_pkg.sv
package mpu_guard_pkg;

  localparam int ADDR_W = 32;
  localparam int SEL_FIELD_W = 4;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE       = 2'd0,
    FLT_BACKGROUND = 2'd1,
    FLT_PERMISSION = 2'd2,
    FLT_ALIGNMENT  = 2'd3
  } flt_class_e;

  typedef enum logic [1:0] {
    MT_STRONG = 2'd0,
    MT_DEVICE = 2'd1,
    MT_NORMAL = 2'd2,
    MT_RSVD   = 2'd3
  } mem_type_e;

  typedef struct packed {
    logic       xn;
    logic [2:0] ap;
    logic [2:0] tex;
    logic       c;
    logic       b;
  } attr_t;

  localparam attr_t ATTR_DEFAULT = '{xn: 1'b0, ap: 3'b011, tex: 3'b000, c: 1'b1, b: 1'b1};

  function automatic attr_t attr_from_word(input logic [31:0] w);
    attr_t a;
    a.xn  = w[12];
    a.ap  = w[10:8];
    a.tex = w[5:3];
    a.c   = w[1];
    a.b   = w[0];
    return a;
  endfunction

  function automatic mem_type_e type_of(input attr_t a);
    mem_type_e t;
    t = MT_RSVD;
    if (a.tex == 3'b000) begin
      if (a.c) t = MT_NORMAL;
      else if (a.b) t = MT_DEVICE;
      else t = MT_STRONG;
    end else if (a.tex == 3'b001) begin
      if (a.c == a.b) t = MT_NORMAL;
    end
    return t;
  endfunction

  function automatic logic ap_is_reserved(input logic [2:0] ap);
    return (ap == 3'b100) || (ap == 3'b111);
  endfunction

  function automatic logic ap_allows(input logic [2:0] ap, input logic priv, input logic wr);
    logic ok;
    case (ap)
      3'b001:  ok = priv;
      3'b010:  ok = priv || !wr;
      3'b011:  ok = 1'b1;
      3'b101:  ok = priv && !wr;
      3'b110:  ok = !wr;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  // Bits that must agree with the base for a region of code N (2^(N+1) bytes).
  function automatic logic [ADDR_W-1:0] span_mask(input logic [4:0] code);
    logic [ADDR_W:0] m;
    m = {(ADDR_W+1){1'b1}} << (6'(code) + 6'd1);
    return m[ADDR_W-1:0];
  endfunction

  // Subregion index: the three address bits just below the region size.
  function automatic logic [2:0] sub_index(input logic [ADDR_W-1:0] addr, input logic [4:0] code);
    logic [ADDR_W-1:0] s;
    s = addr >> (code - 5'd2);
    return s[2:0];
  endfunction

endpackage

// File: rtl/mpu_region_slot.sv
module mpu_region_slot
  import mpu_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_base,
  input  logic              wr_attr,
  input  logic              wr_size,
  input  logic [31:0]       wdata,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              hit,
  output attr_t             attr
);

  logic [ADDR_W-1:5] base_q;
  attr_t             attr_q;
  logic              en_q;
  logic [4:0]        code_q;
  logic [7:0]        sub_off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q    <= '0;
      attr_q    <= '0;
      en_q      <= 1'b0;
      code_q    <= '0;
      sub_off_q <= '0;
    end else begin
      if (wr_base) base_q <= wdata[ADDR_W-1:5];
      if (wr_attr) attr_q <= attr_from_word(wdata);
      if (wr_size) begin
        en_q      <= wdata[0];
        code_q    <= wdata[5:1];
        sub_off_q <= wdata[15:8];
      end
    end
  end

  logic       size_legal;
  logic       in_span;
  logic [2:0] sub_k;
  logic       sub_blocked;

  assign size_legal  = (code_q >= 5'd4);
  assign in_span     = ((({base_q, 5'b0} ^ probe_addr) & span_mask(code_q)) == '0);
  assign sub_k       = sub_index(probe_addr, code_q);
  assign sub_blocked = sub_off_q[sub_k];

  assign hit  = en_q && size_legal && in_span && !sub_blocked;
  assign attr = attr_q;

  // R7: an access in a switched-off subregion never hits this region
  a_r7_blocked_sub_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    sub_blocked |-> !hit);

  // R5: a hit needs a legal size code and the region switched on
  a_r5_hit_needs_legal_size: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (en_q && code_q >= 5'd4));

endmodule

// File: rtl/mpu_pick.sv
module mpu_pick
  import mpu_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 12,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_REGIONS-1:0] hit_vec,
  input  attr_t                  attrs [NUM_REGIONS],
  output logic                   any_hit,
  output logic [IDX_W-1:0]       win_idx,
  output attr_t                  win_attr
);

  always_comb begin
    any_hit  = 1'b0;
    win_idx  = '0;
    win_attr = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hit_vec[i]) begin
        any_hit  = 1'b1;
        win_idx  = IDX_W'(i);
        win_attr = attrs[i];
      end
    end
  end

  // R6: the winner hits and no region above it does
  a_r6_highest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> ((hit_vec >> win_idx) == NUM_REGIONS'(1)));

  a_r6_none_means_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !any_hit |-> (hit_vec == '0));

endmodule

// File: rtl/mpu_guard.sv
module mpu_guard
  import mpu_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic        cfg_priv,
  output logic        cfg_err,
  input  logic        chk_valid,
  input  logic [31:0] chk_addr,
  input  logic        chk_priv,
  input  logic [1:0]  chk_kind,
  input  logic        chk_unaligned,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic [1:0]  rsp_class,
  output logic [1:0]  rsp_mtype
);

  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

  // ---------------- configuration ----------------
  logic                   cfg_ok;
  logic [SEL_FIELD_W-1:0] sel_q;
  logic                   sel_legal;
  logic                   ctrl_en_q;
  logic                   ctrl_bg_q;
  attr_t                  bg_attr_q;
  logic                   cfg_err_q;

  assign cfg_ok    = cfg_we && cfg_priv;
  assign sel_legal = (32'(cfg_wdata[SEL_FIELD_W-1:0]) < NUM_REGIONS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q     <= '0;
      ctrl_en_q <= 1'b0;
      ctrl_bg_q <= 1'b0;
      bg_attr_q <= ATTR_DEFAULT;
      cfg_err_q <= 1'b0;
    end else begin
      cfg_err_q <= cfg_we && !cfg_priv;
      if (cfg_ok) begin
        case (cfg_addr)
          3'd0: if (sel_legal) sel_q <= cfg_wdata[SEL_FIELD_W-1:0];
          3'd4: begin
            ctrl_en_q <= cfg_wdata[0];
            ctrl_bg_q <= cfg_wdata[1];
          end
          3'd5: bg_attr_q <= attr_from_word(cfg_wdata);
          default: ;
        endcase
      end
    end
  end

  assign cfg_err = cfg_err_q;

  // ---------------- region slots ----------------
  logic [NUM_REGIONS-1:0] hit_vec;
  attr_t                  slot_attr [NUM_REGIONS];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_slot
    logic mine;
    assign mine = cfg_ok && (32'(sel_q) == g);
    mpu_region_slot u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_base    (mine && cfg_addr == 3'd1),
      .wr_attr    (mine && cfg_addr == 3'd2),
      .wr_size    (mine && cfg_addr == 3'd3),
      .wdata      (cfg_wdata),
      .probe_addr (chk_addr),
      .hit        (hit_vec[g]),
      .attr       (slot_attr[g])
    );
  end

  logic             pick_any;
  logic [IDX_W-1:0] pick_idx;
  attr_t            pick_attr;

  mpu_pick #(.NUM_REGIONS(NUM_REGIONS)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_vec  (hit_vec),
    .attrs    (slot_attr),
    .any_hit  (pick_any),
    .win_idx  (pick_idx),
    .win_attr (pick_attr)
  );

  // ---------------- access evaluation ----------------
  attr_t      eff_attr;
  mem_type_e  eff_type;
  logic       attr_bad;
  logic       is_write;
  logic       is_fetch;
  logic       perm_hole;
  flt_class_e verdict;
  mem_type_e  verdict_type;

  assign eff_attr  = pick_any ? pick_attr : bg_attr_q;
  assign eff_type  = type_of(eff_attr);
  assign attr_bad  = (eff_type == MT_RSVD) || ap_is_reserved(eff_attr.ap);
  assign is_write  = (chk_kind == ACC_WRITE);
  assign is_fetch  = (chk_kind == ACC_FETCH);
  assign perm_hole = !ap_allows(eff_attr.ap, chk_priv, is_write) || (eff_attr.xn && is_fetch);

  always_comb begin
    verdict      = FLT_NONE;
    verdict_type = eff_type;
    if (!ctrl_en_q) begin
      verdict_type = MT_NORMAL;
    end else if (!pick_any && !ctrl_bg_q) begin
      verdict      = FLT_BACKGROUND;
      verdict_type = MT_STRONG;
    end else if (attr_bad) begin
      verdict      = FLT_PERMISSION;
      verdict_type = MT_STRONG;
    end else if (chk_unaligned && eff_type != MT_NORMAL) begin
      verdict = FLT_ALIGNMENT;
    end else if (perm_hole) begin
      verdict = FLT_PERMISSION;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_class <= FLT_NONE;
      rsp_mtype <= MT_STRONG;
    end else begin
      rsp_valid <= chk_valid;
      rsp_fault <= chk_valid && (verdict != FLT_NONE);
      rsp_class <= chk_valid ? verdict : FLT_NONE;
      rsp_mtype <= chk_valid ? verdict_type : MT_STRONG;
    end
  end

  // R2: with protection off, no response carries a fault
  a_r2_off_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && !ctrl_en_q) |=> !rsp_fault);

  // R4: the error flag follows only a user-level configuration write
  a_r4_err_from_user: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(cfg_we && !cfg_priv));

  // R3: the select register never holds a reserved value
  a_r3_sel_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(sel_q) < NUM_REGIONS);

  // R8: a background fault only when nothing hit and the default map was off
  a_r8_bg_only_unmatched: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && pick_any) |=> (rsp_class != FLT_BACKGROUND));

  // R12: an alignment fault never reports normal memory
  a_r12_align_not_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_class == FLT_ALIGNMENT) |-> (rsp_mtype != MT_NORMAL));

endmodule

// File: tb/mpu_guard_tb_top.sv
module mpu_guard_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_priv = 1'b0;
  logic        cfg_err;
  logic        chk_valid = 1'b0;
  logic [31:0] chk_addr = '0;
  logic        chk_priv = 1'b0;
  logic [1:0]  chk_kind = '0;
  logic        chk_unaligned = 1'b0;
  logic        rsp_valid;
  logic        rsp_fault;
  logic [1:0]  rsp_class;
  logic [1:0]  rsp_mtype;

  always #10 clk = ~clk;

  mpu_guard dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_priv(cfg_priv),
    .cfg_err(cfg_err),
    .chk_valid(chk_valid), .chk_addr(chk_addr), .chk_priv(chk_priv),
    .chk_kind(chk_kind), .chk_unaligned(chk_unaligned),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_class(rsp_class), .rsp_mtype(rsp_mtype)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [4:0] exp_q [$];
  string      tag_q [$];

  localparam logic [1:0] RD = 2'd0, WR = 2'd1, FE = 2'd2;
  localparam logic [1:0] C_NONE = 2'd0, C_BG = 2'd1, C_PERM = 2'd2, C_ALIGN = 2'd3;
  localparam logic [1:0] T_SO = 2'd0, T_DEV = 2'd1, T_NORM = 2'd2;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one access, expected result queued for the monitor
  task automatic access(input logic [31:0] a, input logic p, input logic [1:0] k,
                        input logic u, input logic [1:0] ecls, input logic [1:0] etype,
                        input string tag);
    @(negedge clk);
    chk_valid = 1'b1; chk_addr = a; chk_priv = p; chk_kind = k; chk_unaligned = u;
    exp_q.push_back({ecls != C_NONE, ecls, etype});
    tag_q.push_back(tag);
    @(negedge clk);
    chk_valid = 1'b0;
  endtask

  task automatic cfg(input logic [2:0] a, input logic [31:0] d, input logic p);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_priv = p;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R4 cfg_err after write", {31'b0, cfg_err}, {31'b0, !p});
  endtask

  // monitor: compare each response against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected response", 32'd1, 32'd0);
      end else begin
        logic [4:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {27'b0, rsp_fault, rsp_class, rsp_mtype}, {27'b0, e});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
    check("R1 cfg_err after reset", {31'b0, cfg_err}, 32'd0);

    // R2: protection off, anything passes as normal
    access(32'h0000_1000, 1'b0, WR, 1'b1, C_NONE, T_NORM, "R2 disabled passes");

    // R8: on, no regions, background off
    cfg(3'd4, 32'h1, 1'b1);
    access(32'h0000_1000, 1'b1, RD, 1'b0, C_BG, T_SO, "R8 background fault");
    // R1: reset default attributes (0x303) with background enabled
    cfg(3'd4, 32'h3, 1'b1);
    access(32'h0000_1000, 1'b0, WR, 1'b0, C_NONE, T_NORM, "R1 R8 default map full normal");

    // region 0: base 0, 1 MB (code 19), full access normal
    cfg(3'd0, 32'd0, 1'b1);
    cfg(3'd1, 32'h0000_0000, 1'b1);
    cfg(3'd2, 32'h0000_030B, 1'b1);
    cfg(3'd3, 32'h0000_0027, 1'b1);
    cfg(3'd4, 32'h1, 1'b1);
    access(32'h0008_0000, 1'b0, WR, 1'b0, C_NONE, T_NORM, "R5 region0 hit");
    access(32'h0010_0000, 1'b0, RD, 1'b0, C_BG, T_SO, "R5 R8 just past region0");

    // region 1: 0x40000, 64 KB (code 15), XN, privileged read only, device
    cfg(3'd0, 32'd1, 1'b1);
    cfg(3'd1, 32'h0004_0000, 1'b1);
    cfg(3'd2, 32'h0000_1501, 1'b1);
    cfg(3'd3, 32'h0000_001F, 1'b1);
    access(32'h0004_0000, 1'b1, RD, 1'b0, C_NONE, T_DEV, "R6 R11 region1 device read");
    access(32'h0004_0000, 1'b1, WR, 1'b0, C_PERM, T_DEV, "R9 priv write to ap101");
    access(32'h0004_0000, 1'b0, RD, 1'b0, C_PERM, T_DEV, "R9 user read to ap101");
    access(32'h0004_0000, 1'b1, FE, 1'b0, C_PERM, T_DEV, "R10 fetch from xn");
    access(32'h0004_0004, 1'b1, RD, 1'b1, C_ALIGN, T_DEV, "R12 unaligned device");
    access(32'h0004_0004, 1'b1, WR, 1'b1, C_ALIGN, T_DEV, "R12 align before perm");
    access(32'h0005_0000, 1'b0, WR, 1'b0, C_NONE, T_NORM, "R6 above region1 uses region0");

    // R7: disable subregion 2 of region 1 (8 KB each)
    cfg(3'd3, 32'h0000_041F, 1'b1);
    access(32'h0004_4000, 1'b0, WR, 1'b0, C_NONE, T_NORM, "R7 disabled sub falls to region0");
    access(32'h0004_6000, 1'b0, WR, 1'b0, C_PERM, T_DEV, "R7 neighbour sub still region1");

    // R3: reserved select ignored; next attr write still lands on region 1
    cfg(3'd0, 32'd12, 1'b1);
    cfg(3'd2, 32'h0000_0003, 1'b1);
    access(32'h0004_0000, 1'b1, RD, 1'b0, C_PERM, T_NORM, "R3 R9 select kept, ap000");

    // R4: user write to size word of region 1 and to control ignored
    cfg(3'd3, 32'h0000_0000, 1'b0);
    cfg(3'd4, 32'h0000_0000, 1'b0);
    access(32'h0004_0000, 1'b1, RD, 1'b0, C_PERM, T_NORM, "R4 user cfg write ignored");

    // region 11: whole space, read only both, strongly-ordered
    cfg(3'd0, 32'd11, 1'b1);
    cfg(3'd1, 32'h0000_0000, 1'b1);
    cfg(3'd2, 32'h0000_0600, 1'b1);
    cfg(3'd3, 32'h0000_003F, 1'b1);
    access(32'h0008_0000, 1'b0, RD, 1'b0, C_NONE, T_SO, "R6 R11 region11 wins strongly-ordered");
    access(32'h0008_0000, 1'b0, WR, 1'b0, C_PERM, T_SO, "R9 write to ap110");
    access(32'h0008_0001, 1'b0, RD, 1'b1, C_ALIGN, T_SO, "R12 unaligned strongly-ordered");
    access(32'hFFFF_0000, 1'b0, RD, 1'b0, C_NONE, T_SO, "R5 4GB region covers top");

    // R13: reserved encodings
    cfg(3'd2, 32'h0000_0700, 1'b1);
    access(32'h0008_0000, 1'b1, RD, 1'b0, C_PERM, T_SO, "R13 ap111 reserved");
    cfg(3'd2, 32'h0000_0310, 1'b1);
    access(32'h0008_0000, 1'b1, RD, 1'b0, C_PERM, T_SO, "R13 tex010 reserved");

    // R5: size code 3 never matches
    cfg(3'd3, 32'h0000_0007, 1'b1);
    access(32'h0008_0000, 1'b0, WR, 1'b0, C_NONE, T_NORM, "R5 invalid size code no match");

    // R5: misaligned base masked, region 2 256 MB at 0x2000_0000
    cfg(3'd0, 32'd2, 1'b1);
    cfg(3'd1, 32'h2000_1234, 1'b1);
    cfg(3'd2, 32'h0000_030B, 1'b1);
    cfg(3'd3, 32'h0000_0037, 1'b1);
    access(32'h2000_0000, 1'b0, WR, 1'b0, C_NONE, T_NORM, "R5 masked base low end");
    access(32'h2FFF_FFFC, 1'b0, WR, 1'b0, C_NONE, T_NORM, "R5 masked base high end");
    access(32'h3000_0000, 1'b0, RD, 1'b0, C_BG, T_SO, "R8 past region2");

    // R8: background attribute word reprogrammed to device, privileged only
    cfg(3'd5, 32'h0000_0101, 1'b1);
    cfg(3'd4, 32'h3, 1'b1);
    access(32'h3000_0000, 1'b1, WR, 1'b0, C_NONE, T_DEV, "R8 new default attrs");
    access(32'h3000_0000, 1'b0, RD, 1'b0, C_PERM, T_DEV, "R8 R9 default attrs user blocked");

    // R2: turn off again
    cfg(3'd4, 32'h0, 1'b1);
    access(32'h3000_0000, 1'b0, FE, 1'b1, C_NONE, T_NORM, "R2 disabled again");

    repeat (3) @(negedge clk);
    check("R2 all responses seen", exp_q.size(), 32'd0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule